// File: doc/BRIEF.md
# Nibble-RAM Cartridge Bank Controller

This block is the address mapper for a plug-in program cartridge on an 8-bit CPU bus. It covers the lower 32 KiB of the CPU map, which is program ROM. The low 16 KiB (0x0000–0x3FFF) always points at physical ROM page 0. The upper 16 KiB (0x4000–0x7FFF) points at a page chosen by a 4-bit page register. For every ROM read the block produces the physical ROM address. The ROM array sits outside the block and returns the data.

The block also contains a small scratch memory of 512 four-bit cells. It appears in the 8 KiB window 0xA000–0xBFFF. Only the low nine address bits select a cell, so the 512 cells repeat across the whole window. A read returns the cell value with the upper four data bits forced to one. A write keeps only the low four data bits. The scratch memory must be unlocked before use. While it is locked, reads return 0xFF and writes are dropped.

Writes into 0x0000–0x3FFF are control writes. Address bit 8 picks the target. When bit 8 is clear, the write sets the unlock state. When bit 8 is set, the write loads the page register. Reads return their result one clock after the read strobe.

Top module: `nram_bank_ctrl`

## Requirements
- R1: After reset the page register holds 1 and the scratch memory is locked. A read of 0x4123 yields rom_addr 0x04123, and a read of 0xA000 yields rd_data 0xFF.
- R2: A read in 0x0000–0x3FFF gives rd_is_rom=1 and rom_addr = {4'h0, cpu_addr[13:0]}, whatever the page register holds.
- R3: A read in 0x4000–0x7FFF gives rd_is_rom=1 and rom_addr = {page, cpu_addr[13:0]}. The page occupies rom_addr[17:14].
- R4: A write in 0x0000–0x3FFF with cpu_addr[8]=1 loads cpu_wdata[3:0] into the page register. A stored page of 0 is used as page 1.
- R5: A write in 0x0000–0x3FFF with cpu_addr[8]=0 unlocks the scratch memory when cpu_wdata[3:0]==4'hA and locks it for any other low nibble. The upper nibble is ignored, and the page register is not touched.
- R6: While unlocked, a read in 0xA000–0xBFFF returns {4'hF, stored nibble}.
- R7: While unlocked, a write in 0xA000–0xBFFF stores only cpu_wdata[3:0].
- R8: The scratch cell index is cpu_addr[8:0], so addresses that differ only in bits 12:9 reach the same cell. For example, 0xA003, 0xA203 and 0xBC03 are one cell.
- R9: While locked, a read in 0xA000–0xBFFF returns 0xFF, and a write there leaves the stored cells unchanged.
- R10: Writes in 0x4000–0x7FFF change neither the page register nor the unlock state.
- R11: A read outside both ROM windows and the scratch window gives rd_is_rom=0 and rd_data=0xFF.
- R12: rd_valid is 1 in exactly the cycle after a cycle with cpu_rd=1, and 0 otherwise. cpu_rd and cpu_wr are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| rd_valid | output | 1 | Read result present (cycle after cpu_rd) |
| rd_is_rom | output | 1 | Read targeted ROM; external ROM supplies the data at rom_addr |
| rd_data | output | 8 | Data for non-ROM reads (scratch memory or 0xFF) |
| rom_addr | output | 18 | Physical ROM byte address of the latest ROM read |

## Verification
A corrupted page register shows up on the very next read in 0x4000–0x7FFF as a wrong value in rom_addr[17:14]. Reads in the fixed window must stay on page 0 however the page register was loaded. A wrong unlock state or a wrong cell index surfaces one cycle after a scratch read, as an unexpected 0xFF or a wrong low nibble. A write that should have been dropped is only visible later, so the bench unlocks again and reads the cell back. A wrong control-target decode on address bit 8 surfaces either as a moved page or as a changed unlock state, each on the next read of the affected window.

// File: rtl/nram_pkg.sv
package nram_pkg;
  // CPU map regions seen by this mapper
  typedef enum logic [1:0] {
    RGN_FIXED  = 2'd0,
    RGN_BANKED = 2'd1,
    RGN_XRAM   = 2'd2,
    RGN_OPEN   = 2'd3
  } rgn_e;

  // Nibble value that unlocks the scratch memory
  localparam logic [3:0] UNLOCK_NIB = 4'hA;
endpackage

// File: rtl/nram_decode.sv
module nram_decode
  import nram_pkg::*;
(
  input  logic [2:0] addr_top,
  output rgn_e       rgn
);
  always_comb begin
    unique case (addr_top)
      3'b000, 3'b001: rgn = RGN_FIXED;
      3'b010, 3'b011: rgn = RGN_BANKED;
      3'b101:         rgn = RGN_XRAM;
      default:        rgn = RGN_OPEN;
    endcase
  end
endmodule

// File: rtl/nram_ctl_regs.sv
module nram_ctl_regs
  import nram_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic              sel_bank,
  input  logic [NIB_W-1:0]  wnib,
  output logic              ram_en,
  output logic [BANK_W-1:0] bank_eff
);
  localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

  logic [BANK_W-1:0] bank_q;
  logic              en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= BANK_ONE;
      en_q   <= 1'b0;
    end else if (ctl_wr) begin
      if (sel_bank) bank_q <= wnib[BANK_W-1:0];
      else          en_q   <= (wnib[3:0] == UNLOCK_NIB);
    end
  end

  assign ram_en   = en_q;
  assign bank_eff = (bank_q == '0) ? BANK_ONE : bank_q;
endmodule

// File: rtl/nram_rom_map.sv
module nram_rom_map
  import nram_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int OFS_W  = 14,
  localparam int PHYS_W = BANK_W + OFS_W
) (
  input  rgn_e              rgn,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [BANK_W-1:0] bank,
  output logic [PHYS_W-1:0] phys
);
  always_comb begin
    if (rgn == RGN_BANKED) phys = {bank, ofs};
    else                   phys = {{BANK_W{1'b0}}, ofs};
  end
endmodule

// File: rtl/nram_store.sv
module nram_store #(
  parameter int DEPTH = 512,
  parameter int NIB_W = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [NIB_W-1:0] wnib,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [NIB_W-1:0] q
);
  logic [NIB_W-1:0] mem [DEPTH];

  // Single clock, synchronous read: maps to a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wnib;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/nram_bank_ctrl.sv
module nram_bank_ctrl
  import nram_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int BANK_W    = 4,
  parameter int OFS_W     = 14,
  parameter int NIB_W     = 4,
  parameter int RAM_DEPTH = 512,
  parameter int SEL_BIT   = 8,
  localparam int RAM_AW   = $clog2(RAM_DEPTH),
  localparam int PHYS_W   = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic              rd_valid,
  output logic              rd_is_rom,
  output logic [DATA_W-1:0] rd_data,
  output logic [PHYS_W-1:0] rom_addr
);
  rgn_e              rgn;
  logic              ram_en;
  logic [BANK_W-1:0] bank_eff;
  logic [PHYS_W-1:0] phys_d;
  logic [NIB_W-1:0]  ram_q;
  logic              is_rom_rgn;
  logic              unused_hi;

  assign unused_hi = ^cpu_wdata[DATA_W-1:NIB_W];

  nram_decode u_dec (
    .addr_top (cpu_addr[ADDR_W-1 -: 3]),
    .rgn      (rgn)
  );

  nram_ctl_regs #(.BANK_W(BANK_W), .NIB_W(NIB_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (cpu_wr && (rgn == RGN_FIXED)),
    .sel_bank (cpu_addr[SEL_BIT]),
    .wnib     (cpu_wdata[NIB_W-1:0]),
    .ram_en   (ram_en),
    .bank_eff (bank_eff)
  );

  nram_rom_map #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_map (
    .rgn  (rgn),
    .ofs  (cpu_addr[OFS_W-1:0]),
    .bank (bank_eff),
    .phys (phys_d)
  );

  nram_store #(.DEPTH(RAM_DEPTH), .NIB_W(NIB_W)) u_store (
    .clk   (clk),
    .we    (cpu_wr && (rgn == RGN_XRAM) && ram_en),
    .waddr (cpu_addr[RAM_AW-1:0]),
    .wnib  (cpu_wdata[NIB_W-1:0]),
    .re    (cpu_rd && (rgn == RGN_XRAM)),
    .raddr (cpu_addr[RAM_AW-1:0]),
    .q     (ram_q)
  );

  assign is_rom_rgn = (rgn == RGN_FIXED) || (rgn == RGN_BANKED);

  logic              vld_q;
  logic              rom_q;
  logic              ram_on_q;
  logic [PHYS_W-1:0] rom_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q      <= 1'b0;
      rom_q      <= 1'b0;
      ram_on_q   <= 1'b0;
      rom_addr_q <= '0;
    end else begin
      vld_q    <= cpu_rd;
      rom_q    <= cpu_rd && is_rom_rgn;
      ram_on_q <= cpu_rd && (rgn == RGN_XRAM) && ram_en;
      if (cpu_rd && is_rom_rgn) rom_addr_q <= phys_d;
    end
  end

  assign rd_valid  = vld_q;
  assign rd_is_rom = rom_q;
  assign rom_addr  = rom_addr_q;
  assign rd_data   = ram_on_q ? {{(DATA_W-NIB_W){1'b1}}, ram_q} : '1;
endmodule

// File: rtl/nram_bank_chk.sv
module nram_bank_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 4,
  parameter int OFS_W  = 14,
  localparam int PHYS_W = BANK_W + OFS_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              ram_en,
  input logic              rd_valid,
  input logic              rd_is_rom,
  input logic [DATA_W-1:0] rd_data,
  input logic [PHYS_W-1:0] rom_addr
);
  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    cpu_rd |=> rd_valid); // R12
  AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> !rd_valid); // R12
  AST_FIXED_PAGE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[ADDR_W-1 -: 2] == 2'b00) |=> (rd_is_rom && rom_addr[PHYS_W-1 -: BANK_W] == '0)); // R2
  AST_BANKED_PAGE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[ADDR_W-1 -: 2] == 2'b01) |=> (rd_is_rom && rom_addr[PHYS_W-1 -: BANK_W] != '0)); // R4
  AST_ROM_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_addr[ADDR_W-1]) |=> (rom_addr[OFS_W-1:0] == $past(cpu_addr[OFS_W-1:0]))); // R3
  AST_UPPER_NIB_HIGH: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_is_rom) |-> (rd_data[DATA_W-1:4] == '1)); // R6
  AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !ram_en && cpu_addr[ADDR_W-1 -: 3] == 3'b101) |=> (rd_data == '1)); // R9
  AST_OPEN_NOT_ROM: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[ADDR_W-1]) |=> !rd_is_rom); // R11
endmodule

bind nram_bank_ctrl nram_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .OFS_W(OFS_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_addr  (cpu_addr),
  .cpu_rd    (cpu_rd),
  .ram_en    (ram_en),
  .rd_valid  (rd_valid),
  .rd_is_rom (rd_is_rom),
  .rd_data   (rd_data),
  .rom_addr  (rom_addr)
);

// File: tb/nram_bank_ctrl_bench.sv
module nram_bank_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic        rd_valid;
  logic        rd_is_rom;
  logic [7:0]  rd_data;
  logic [17:0] rom_addr;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nram_bank_ctrl u_nram_bank_ctrl (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rd_valid(rd_valid),
    .rd_is_rom(rd_is_rom), .rd_data(rd_data), .rom_addr(rom_addr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp = n_cmp + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  // Read strobe for one cycle; results are sampled at the following negedge
  task automatic rd(input logic [15:0] a, output logic vld, output logic isrom,
                    output logic [7:0] d, output logic [17:0] ra);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    vld = rd_valid; isrom = rd_is_rom; d = rd_data; ra = rom_addr;
    cpu_rd = 1'b0;
  endtask

  task automatic rom_rd(input string req, input logic [15:0] a, input logic [3:0] page);
    logic v, r; logic [7:0] d; logic [17:0] ra;
    rd(a, v, r, d, ra);
    chk(req, {v, r}, 2'b11);
    chk(req, ra, {page, a[13:0]});
  endtask

  task automatic ram_rd(input string req, input logic [15:0] a, input logic [7:0] exp);
    logic v, r; logic [7:0] d; logic [17:0] ra;
    rd(a, v, r, d, ra);
    chk(req, {v, r}, 2'b10);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    chk("R12 idle", rd_valid, 1'b0);
    rom_rd("R1 page", 16'h4123, 4'h1);
    ram_rd("R1 locked", 16'hA000, 8'hFF);
    @(negedge clk);
    chk("R12 after read", rd_valid, 1'b0);
  endtask

  task automatic t_fixed();
    wr(16'h2100, 8'h05);
    rom_rd("R2 low", 16'h0000, 4'h0);
    rom_rd("R2 top", 16'h3FFF, 4'h0);
    rom_rd("R2 mid", 16'h2ABC, 4'h0);
  endtask

  task automatic t_bank();
    rom_rd("R3 page5", 16'h4567, 4'h5);
    wr(16'h2100, 8'h07);
    rom_rd("R3 page7", 16'h4000, 4'h7);
    wr(16'h3F00, 8'hF3);
    rom_rd("R4 low nibble", 16'h5ABC, 4'h3);
    wr(16'h2100, 8'h00);
    rom_rd("R4 zero as one", 16'h7FFF, 4'h1);
    wr(16'h0100, 8'h0F);
    rom_rd("R3 page15", 16'h4001, 4'hF);
  endtask

  task automatic t_enable();
    wr(16'h0000, 8'h0A);
    wr(16'hA005, 8'h3C);
    ram_rd("R5 unlock", 16'hA005, 8'hFC);
    wr(16'h2000, 8'h1A);
    ram_rd("R5 upper nibble ignored", 16'hA005, 8'hFC);
    rom_rd("R5 page untouched", 16'h4000, 4'hF);
    wr(16'h0000, 8'h0B);
    ram_rd("R5 lock", 16'hA005, 8'hFF);
    wr(16'hA005, 8'h07);
    wr(16'h00FF, 8'hAA);
    ram_rd("R9 write dropped", 16'hA005, 8'hFC);
  endtask

  task automatic t_nibble();
    wr(16'hA010, 8'h5E);
    ram_rd("R7 low nibble", 16'hA010, 8'hFE);
    wr(16'hA1FF, 8'hF0);
    ram_rd("R6 zero nibble", 16'hA1FF, 8'hF0);
    wr(16'hA1FF, 8'h09);
    ram_rd("R6 read", 16'hA1FF, 8'hF9);
  endtask

  task automatic t_mirror();
    wr(16'hA003, 8'h09);
    ram_rd("R8 alias 0xA203", 16'hA203, 8'hF9);
    ram_rd("R8 alias 0xBE03", 16'hBE03, 8'hF9);
    wr(16'hBC03, 8'h02);
    ram_rd("R8 alias back", 16'hA003, 8'hF2);
    ram_rd("R8 top cell", 16'hBFFF, 8'hF9);
  endtask

  task automatic t_ignored();
    wr(16'h2100, 8'h06);
    wr(16'h5100, 8'h02);
    wr(16'h7FFF, 8'h0B);
    rom_rd("R10 page kept", 16'h4444, 4'h6);
    ram_rd("R10 unlock kept", 16'hA003, 8'hF2);
    wr(16'h0000, 8'h00);
    wr(16'h4000, 8'h0A);
    ram_rd("R10 no unlock", 16'hA003, 8'hFF);
  endtask

  task automatic t_open();
    logic v, r; logic [7:0] d; logic [17:0] ra;
    wr(16'h0000, 8'h0A);
    rd(16'h8000, v, r, d, ra);
    chk("R11 0x8000", {v, r, d}, {2'b10, 8'hFF});
    rd(16'hC000, v, r, d, ra);
    chk("R11 0xC000", {v, r, d}, {2'b10, 8'hFF});
    rd(16'hFFFF, v, r, d, ra);
    chk("R11 0xFFFF", {v, r, d}, {2'b10, 8'hFF});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fixed();
    t_bank();
    t_enable();
    t_nibble();
    t_mirror();
    t_ignored();
    t_open();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule